// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a lane-parallel arithmetic and logic unit for 64-bit words. Each cycle it takes two operands, an operation code, a lane-width code and a saturation mode. It computes the result for every lane at once and presents it on a registered output one clock later. The operand word can be treated as eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The choice is made per operation at run time, so one datapath serves byte, halfword and word media kernels without branching.

Arithmetic can wrap or clamp to the lane's signed or unsigned range. Shifts share one count taken from operand B. Compares produce full-lane masks that later bitwise operations can use to select data without branches. Pack turns wide lanes into narrow ones with clamping, taking the lanes of A first and then the lanes of B.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result_o` becomes zero, whatever the inputs are.
- R2: The result of the inputs sampled at a rising edge appears on `result_o` just after that edge and stays there until the next edge.
- R3: Opcode 0 (add) and opcode 1 (subtract, A minus B) with mode 0 or 3 wrap each lane modulo its width, and no carry or borrow crosses a lane boundary. The width code is 0 for 8-bit lanes, 1 for 16-bit lanes, and 2 or 3 for 32-bit lanes.
- R4: With mode 1, add and subtract clamp a signed overflow to the lane's most positive value and a signed underflow to its most negative value.
- R5: With mode 2, unsigned add clamps to all ones on carry out and unsigned subtract clamps to zero on borrow.
- R6: Opcodes 2 (A and B), 3 (A and not B), 4 (A or B) and 5 (A xor B) act on the whole 64-bit word and ignore the width code.
- R7: Opcodes 6 (logical left), 7 (logical right) and 8 (arithmetic right) shift each lane by the count in B[5:0]. A count equal to or above the lane width gives zero for the logical shifts and a copy of the lane's sign bit in every bit for the arithmetic shift.
- R8: Opcode 9 (equal) and opcode 10 (signed A greater than B) set each lane to all ones when the test holds and to all zeros when it does not.
- R9: Opcode 11 (pack) with width code 1 narrows each 16-bit lane to 8 bits, and with width code 2 or 3 narrows each 32-bit lane to 16 bits. Sources are read as signed. Narrowed lanes of A fill the low half of the result in lane order and those of B fill the high half. Modes 0, 1 and 3 clamp to the signed range of the narrow lane.
- R10: Pack with mode 2 clamps negative sources to zero and sources above the unsigned maximum of the narrow lane to all ones.
- R11: Opcodes 12 to 15 give a zero result, and pack with width code 0 gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B; bits 5:0 also give the shift count |
| op_i | input | 4 | Operation code (see R3 to R11) |
| lane_w_i | input | 2 | Lane width code: 0 = 8, 1 = 16, 2 or 3 = 32 |
| sat_i | input | 2 | Saturation mode: 0/3 wrap, 1 signed, 2 unsigned |
| result_o | output | 64 | Registered result |

## Verification
Every result is due on the first rising edge after its operands are applied, because one register stands between the inputs and `result_o`. The driver pushes the expected word into the scoreboard just after that edge. The monitor compares it on the following falling edge, while the output still holds it and before the next edge can replace it. One directed check changes the inputs between edges and confirms that the output keeps the old value until the edge, then shows the new value one edge later.

// File: rtl/simd_alu_pkg.sv
// Package: shared encodings for the packed SIMD ALU.
// Assumes a 4-bit operation code, a 2-bit lane width code and a 2-bit saturation mode.
package simd_alu_pkg;

    localparam int WORD_W = 64;

    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_SUB  = 4'd1;
    localparam logic [3:0] OP_AND  = 4'd2;
    localparam logic [3:0] OP_ANDN = 4'd3;
    localparam logic [3:0] OP_OR   = 4'd4;
    localparam logic [3:0] OP_XOR  = 4'd5;
    localparam logic [3:0] OP_SHL  = 4'd6;
    localparam logic [3:0] OP_SHR  = 4'd7;
    localparam logic [3:0] OP_SAR  = 4'd8;
    localparam logic [3:0] OP_CEQ  = 4'd9;
    localparam logic [3:0] OP_CGT  = 4'd10;
    localparam logic [3:0] OP_PACK = 4'd11;

    typedef enum logic [1:0] {
        LW_8    = 2'd0,
        LW_16   = 2'd1,
        LW_32   = 2'd2,
        LW_32B  = 2'd3
    } lane_w_e;

    typedef enum logic [1:0] {
        SAT_WRAP  = 2'd0,
        SAT_SGN   = 2'd1,
        SAT_UNS   = 2'd2,
        SAT_WRAPB = 2'd3
    } sat_mode_e;

endpackage

// File: rtl/simd_lane.sv
// Module: one lane of W bits. It covers add/sub with optional clamping, the three shifts
// and the two compares. Assumes W <= 32 so a 6-bit count can exceed the lane width.
// Logic operations and pack are handled outside the lane.
module simd_lane
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [5:0]   cnt,
    input  logic [3:0]   op,
    input  sat_mode_e    mode,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic         is_sub;
    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic [W-1:0] raw;
    logic         ovf_s;
    logic [W-1:0] arith;
    logic         big;
    logic [W-1:0] shl_v, shr_v, sar_v;

    // Adder with operand inversion for subtract; carry out is kept for unsigned clamping.
    always_comb begin
        is_sub = (op == OP_SUB);
        b_eff  = is_sub ? ~b : b;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        raw    = sum[W-1:0];
        ovf_s  = (a[W-1] == b_eff[W-1]) && (raw[W-1] != a[W-1]);
    end

    // Clamp the adder output according to the saturation mode.
    always_comb begin
        arith = raw;
        case (mode)
            SAT_SGN: if (ovf_s) arith = a[W-1] ? SMIN : SMAX;
            SAT_UNS: begin
                if (is_sub && !sum[W])  arith = '0;
                if (!is_sub && sum[W])  arith = '1;
            end
            default: arith = raw;
        endcase
    end

    // Shifts; counts at or beyond the lane width flush to zero or to the sign.
    always_comb begin
        big   = ({1'b0, cnt} >= 7'(W));
        shl_v = big ? '0 : (a << cnt);
        shr_v = big ? '0 : (a >> cnt);
        sar_v = big ? {W{a[W-1]}} : W'($signed(a) >>> cnt);
    end

    // Select the lane result for the requested operation.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB: y = arith;
            OP_SHL:         y = shl_v;
            OP_SHR:         y = shr_v;
            OP_SAR:         y = sar_v;
            OP_CEQ:         y = (a == b) ? '1 : '0;
            OP_CGT:         y = ($signed(a) > $signed(b)) ? '1 : '0;
            default:        y = '0;
        endcase
    end

    // Lane-level properties of the clamped arithmetic and the arithmetic shift.
    always_comb begin
        if (op == OP_ADD && mode == SAT_UNS) begin
            AST_UNS_ADD_NO_WRAP: assert (y >= a); // R5
        end
        if (op == OP_SUB && mode == SAT_UNS) begin
            AST_UNS_SUB_FLOOR: assert (y <= a); // R5
        end
        if (op == OP_ADD && mode == SAT_SGN && a[W-1] == b[W-1]) begin
            AST_SGN_ADD_KEEPS_SIGN: assert (y[W-1] == a[W-1]); // R4
        end
        if (op == OP_SAR) begin
            AST_SAR_KEEPS_SIGN: assert (y[W-1] == a[W-1]); // R7
        end
    end

endmodule

// File: rtl/simd_pack.sv
// Module: saturating narrowing pack. It narrows 16->8 for width code 1 and 32->16 for
// width codes 2/3, placing A's lanes low and B's lanes high. Sources are read as signed.
module simd_pack
    import simd_alu_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  lane_w_e       lw,
    input  sat_mode_e     mode,
    output logic [DW-1:0] y
);

    localparam int N16 = DW / 16;
    localparam int N32 = DW / 32;

    logic [DW-1:0] p8, p16;
    logic          uns;

    assign uns = (mode == SAT_UNS);

    // Clamp a signed 16-bit value into an 8-bit lane.
    function automatic logic [7:0] nar16(input logic [15:0] x, input logic u);
        if (u) begin
            if (x[15])             return 8'h00;
            else if (x > 16'h00FF) return 8'hFF;
            else                   return x[7:0];
        end else begin
            if ($signed(x) > 16'sh007F)       return 8'h7F;
            else if ($signed(x) < -16'sh0080) return 8'h80;
            else                              return x[7:0];
        end
    endfunction

    // Clamp a signed 32-bit value into a 16-bit lane.
    function automatic logic [15:0] nar32(input logic [31:0] x, input logic u);
        if (u) begin
            if (x[31])                  return 16'h0000;
            else if (x > 32'h0000_FFFF) return 16'hFFFF;
            else                        return x[15:0];
        end else begin
            if ($signed(x) > 32'sh0000_7FFF)       return 16'h7FFF;
            else if ($signed(x) < -32'sh0000_8000) return 16'h8000;
            else                                   return x[15:0];
        end
    endfunction

    for (genvar g = 0; g < N16; g++) begin : g_p8
        assign p8[g*8 +: 8]         = nar16(a[g*16 +: 16], uns);
        assign p8[(g+N16)*8 +: 8]   = nar16(b[g*16 +: 16], uns);
    end

    for (genvar g = 0; g < N32; g++) begin : g_p16
        assign p16[g*16 +: 16]       = nar32(a[g*32 +: 32], uns);
        assign p16[(g+N32)*16 +: 16] = nar32(b[g*32 +: 32], uns);
    end

    // Pick the narrowing by source width; 8-bit sources have no narrower lane.
    always_comb begin
        case (lw)
            LW_16:        y = p8;
            LW_32, LW_32B: y = p16;
            default:      y = '0;
        endcase
    end

    // An unsigned 16->8 pack of a negative source lane of A must give a zero byte.
    always_comb begin
        if (lw == LW_16 && uns && a[15]) begin
            AST_PACK_UNS_NEG_ZERO: assert (y[7:0] == 8'h00); // R10
        end
    end

endmodule

// File: rtl/simd_sat_alu.sv
// Module: top of the packed SIMD ALU. It replicates lane units for each width and selects
// one by the width code. Logic ops and pack are added, and the result is registered.
// Assumes DATA_W is a multiple of 32; reset is synchronous and active low.
module simd_sat_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        lane_w_i,
    input  logic [1:0]        sat_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int N8  = DATA_W / 8;
    localparam int N16 = DATA_W / 16;
    localparam int N32 = DATA_W / 32;

    lane_w_e           lw;
    sat_mode_e         mode;
    logic [DATA_W-1:0] r8, r16, r32, lane_r, pack_r, nxt;

    assign lw   = lane_w_e'(lane_w_i);
    assign mode = sat_mode_e'(sat_i);

    for (genvar g = 0; g < N8; g++) begin : g_l8
        simd_lane #(.W(8)) u_lane (
            .a(a_i[g*8 +: 8]), .b(b_i[g*8 +: 8]), .cnt(b_i[5:0]),
            .op(op_i), .mode(mode), .y(r8[g*8 +: 8])
        );
    end

    for (genvar g = 0; g < N16; g++) begin : g_l16
        simd_lane #(.W(16)) u_lane (
            .a(a_i[g*16 +: 16]), .b(b_i[g*16 +: 16]), .cnt(b_i[5:0]),
            .op(op_i), .mode(mode), .y(r16[g*16 +: 16])
        );
    end

    for (genvar g = 0; g < N32; g++) begin : g_l32
        simd_lane #(.W(32)) u_lane (
            .a(a_i[g*32 +: 32]), .b(b_i[g*32 +: 32]), .cnt(b_i[5:0]),
            .op(op_i), .mode(mode), .y(r32[g*32 +: 32])
        );
    end

    simd_pack #(.DW(DATA_W)) u_pack (
        .a(a_i), .b(b_i), .lw(lw), .mode(mode), .y(pack_r)
    );

    // Choose the lane array that matches the width code.
    always_comb begin
        case (lw)
            LW_8:    lane_r = r8;
            LW_16:   lane_r = r16;
            default: lane_r = r32;
        endcase
    end

    // Final operation select, including full-width logic operations.
    always_comb begin
        case (op_i)
            OP_ADD, OP_SUB, OP_SHL, OP_SHR,
            OP_SAR, OP_CEQ, OP_CGT: nxt = lane_r;
            OP_AND:                 nxt = a_i & b_i;
            OP_ANDN:                nxt = a_i & ~b_i;
            OP_OR:                  nxt = a_i | b_i;
            OP_XOR:                 nxt = a_i ^ b_i;
            OP_PACK:                nxt = pack_r;
            default:                nxt = '0;
        endcase
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= nxt;
    end

    // True when every byte is either all zeros or all ones.
    function automatic logic bytes_are_masks(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N8; i++) begin
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (result_o == '0)); // R1

    AST_CMP_IS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CEQ || op_i == OP_CGT) |=> bytes_are_masks(result_o)); // R8

    AST_XOR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_XOR) |=> (result_o == $past(a_i ^ b_i))); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd12) |=> (result_o == '0)); // R11

endmodule

// File: tb/simd_sat_alu_bench.sv
// Bench: scoreboard. The driver applies one operation per cycle and queues the model's
// expected word; the monitor pops and compares on each falling edge.
module simd_sat_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [3:0]  op_i = '0;
    logic [1:0]  lane_w_i = '0;
    logic [1:0]  sat_i = '0;
    logic [63:0] result_o;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    simd_sat_alu u_simd_sat_alu (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .op_i(op_i),
        .lane_w_i(lane_w_i), .sat_i(sat_i), .result_o(result_o)
    );

    function automatic int width_of(input int w);
        return (w == 0) ? 8 : (w == 1) ? 16 : 32;
    endfunction

    // Signed value of lane i of width W.
    function automatic longint lane_s(input logic [63:0] x, input int i, input int W);
        longint one, u;
        one = 1;
        u = longint'(x >> (i*W)) & ((one << W) - 1);
        return (u >= (one << (W-1))) ? u - (one << W) : u;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input int op, input int w, input int m);
        int W, n, cnt, nw;
        longint one, msk, smax, smin, ua, ub, sa, sb, v, hi, lo;
        logic [63:0] r;
        W = width_of(w); n = 64 / W; one = 1; r = '0;
        msk = (one << W) - 1; smax = (one << (W-1)) - 1; smin = -(one << (W-1));
        cnt = int'(b[5:0]);
        case (op)
            2: return a & b;
            3: return a & ~b;
            4: return a | b;
            5: return a ^ b;
            11: begin
                if (W == 8) return '0;
                nw = W / 2;
                hi = (m == 2) ? ((one << nw) - 1) : ((one << (nw-1)) - 1);
                lo = (m == 2) ? 0 : -(one << (nw-1));
                for (int i = 0; i < 2*n; i++) begin
                    v = (i < n) ? lane_s(a, i, W) : lane_s(b, i-n, W);
                    if (v > hi) v = hi;
                    if (v < lo) v = lo;
                    r = r | ((64'(v) & 64'((one << nw) - 1)) << (i*nw));
                end
                return r;
            end
            default: ;
        endcase
        if (op > 10) return '0;
        for (int i = 0; i < n; i++) begin
            sa = lane_s(a, i, W); sb = lane_s(b, i, W);
            ua = sa & msk; ub = sb & msk;
            v = 0;
            case (op)
                0, 1: begin
                    if (m == 2) begin
                        v = (op == 0) ? ua + ub : ua - ub;
                        if (v > msk) v = msk;
                        if (v < 0) v = 0;
                    end else if (m == 1) begin
                        v = (op == 0) ? sa + sb : sa - sb;
                        if (v > smax) v = smax;
                        if (v < smin) v = smin;
                    end else begin
                        v = (op == 0) ? ua + ub : ua - ub;
                    end
                end
                6: v = (cnt >= W) ? 0 : (ua << cnt);
                7: v = (cnt >= W) ? 0 : (ua >> cnt);
                8: v = (cnt >= W) ? ((sa < 0) ? -1 : 0) : (sa >>> cnt);
                9: v = (ua == ub) ? -1 : 0;
                10: v = (sa > sb) ? -1 : 0;
                default: v = 0;
            endcase
            r = r | ((64'(v) & 64'(msk)) << (i*W));
        end
        return r;
    endfunction

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: apply one operation and queue its expected result after the capturing edge.
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input int op,
                         input int w, input int m, input string tag);
        item_t it;
        @(negedge clk);
        a_i = a; b_i = b; op_i = 4'(op); lane_w_i = 2'(w); sat_i = 2'(m);
        @(posedge clk);
        #1;
        it.exp = model(a, b, op, w, m);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the output with the oldest queued item away from the rising edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(result_o, it.exp, it.tag);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] e1;
        // R1: reset clears the output even with live inputs.
        a_i = '1; b_i = 64'h0101_0101_0101_0101; op_i = 4'd0;
        repeat (3) @(posedge clk);
        #1 check(result_o, 64'h0, "R1 reset clear");
        @(negedge clk);
        rst_n = 1'b1;

        // R3: wrap per lane with no carry across lanes.
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0, "R3 add8 wrap");
        apply(64'h0000_0001_0000_0000, 64'h0002_0002_0002_0002, 1, 1, 3, "R3 sub16 wrap");
        apply(64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0007, 0, 3, 0, "R3 add32 width code 3");
        // R4: signed clamp.
        apply(64'h7F80_7F80_0102_0304, 64'h0101_8080_0101_0101, 0, 0, 1, "R4 add8 signed sat");
        apply(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 1, 2, 1, "R4 sub32 signed sat");
        // R5: unsigned clamp.
        apply(64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFF_0001, 0, 1, 2, "R5 add16 unsigned sat");
        apply(64'h1020_3040_5060_7080, 64'h2010_4030_6050_8070, 1, 0, 2, "R5 sub8 unsigned floor");
        // R6: full-width logic, width code ignored.
        apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 2, 0, 0, "R6 and");
        apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 3, 1, 0, "R6 and-not");
        apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 4, 2, 0, "R6 or");
        apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 5, 3, 0, "R6 xor");
        // R7: shifts and oversize counts.
        apply(64'h8142_2418_FF01_7E81, 64'd3, 6, 0, 0, "R7 shl8 by 3");
        apply(64'h8000_FFFF_1234_0001, 64'd16, 7, 1, 0, "R7 shr16 by 16 flushes");
        apply(64'h8000_0000_7FFF_FFFF, 64'd40, 8, 2, 0, "R7 sar32 by 40 sign fill");
        apply(64'h80F0_7F10_C001_8181, 64'd2, 8, 0, 0, "R7 sar8 by 2");
        // R8: compare masks.
        apply(64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFE, 9, 1, 0, "R8 eq16");
        apply(64'h80FF_017F_0500_FE02, 64'h7F00_0080_0600_FD02, 10, 0, 0, "R8 gt8 signed");
        // R9: signed packs.
        apply(64'h0080_FF7F_007F_FF80, 64'h1234_8000_0000_FFFF, 11, 1, 0, "R9 pack16to8 signed");
        apply(64'h0001_0000_FFFF_0000, 64'h0000_7FFF_FFFF_8000, 11, 2, 1, "R9 pack32to16 signed");
        // R10: unsigned packs.
        apply(64'h0100_00FF_8000_0042, 64'hFFFF_0000_00FE_0300, 11, 1, 2, "R10 pack16to8 unsigned");
        apply(64'hFFFF_FFFF_0001_2345, 64'h0000_FFFF_0000_0000, 11, 3, 2, "R10 pack32to16 unsigned");
        // R11: reserved opcodes and 8-bit pack give zero.
        apply(64'hDEAD_BEEF_DEAD_BEEF, 64'h1111_2222_3333_4444, 13, 0, 0, "R11 reserved opcode");
        apply(64'hDEAD_BEEF_DEAD_BEEF, 64'h1111_2222_3333_4444, 11, 0, 1, "R11 pack width 8");

        // R2: the output holds between edges and takes the new result after one edge.
        apply(64'h0000_0000_0000_00AA, 64'h0000_0000_0000_0055, 4, 0, 0, "R2 first op");
        e1 = model(64'h0000_0000_0000_00AA, 64'h0000_0000_0000_0055, 4, 0, 0);
        @(negedge clk);
        #2;
        a_i = 64'h0F0F_0F0F_0F0F_0F0F; b_i = 64'hFFFF_0000_FFFF_0000; op_i = 4'd5;
        #1 check(result_o, e1, "R2 hold before edge");
        @(posedge clk);
        #1 check(result_o, 64'h0F0F_0F0F_0F0F_0F0F ^ 64'hFFFF_0000_FFFF_0000, "R2 due after one edge");

        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule